// File: doc/BRIEF.md
# I2C Target Transmitter with Address-Hold Stretching

This block is the bus side of an I2C target that answers 7-bit addresses and can send data back to a bus controller. SCL and SDA are open-drain. The block samples each line through a short synchronizer and can pull either line low through an output-enable. A local host works the block through a small register-style port: a buffer, a clock-release bit, an ack-decision bit, an ack-status bit, a few status flags and one interrupt flag.

With address-hold switched on, the host decides whether a matching address is acknowledged. After the eighth falling SCL edge of an address that matches, the block holds SCL low and raises the interrupt. It then waits for the host to choose ACK or NACK and to set clock release. For a read request, the block stretches SCL again before every byte it sends. The host loads the byte and sets clock release, the block shifts the byte out most significant bit first, and it records whether the controller acknowledged it. With address-hold off, a matching address is acknowledged at once and no stretch takes place during the address phase.

Top module: `i2ct_target`

## Requirements
- R1: After reset both output-enables are 0, clk_rel is 1, and irq, buf_full and start_seen are 0.
- R2: A Start (SDA falling while SCL is high) sets start_seen. It raises irq only when start_ie is 1.
- R3: With addr_hold_en=1, after the 8th falling SCL edge of a byte whose upper 7 bits equal own_addr, the block does all of the following: clears clk_rel, holds SCL low, raises irq, sets ack_time, sets buf_full, and places the byte (address in bits 7:1, R/W in bit 0) on buf_data.
- R4: A host_rd pulse clears buf_full.
- R5: A host_rel pulse during the address hold frees SCL. The block then drives SDA on the 9th pulse low when host_ack_data=0 (ACK) and leaves it released when host_ack_data=1 (NACK). ack_time clears at the 9th falling edge.
- R6: When the acknowledged address has R/W=1, the block clears clk_rel again after the 9th falling edge, holds SCL and raises irq. rw_flag reads 1.
- R7: host_wr loads the transmit byte and sets buf_full only while the block stretches before a transmit byte. A write at any other time, such as during the address hold, is ignored and leaves buf_full unchanged.
- R8: After host_rel, the 8 transmit bits appear on SDA most significant bit first. SDA only changes while SCL is low.
- R9: The SDA level at the 9th rise after a transmit byte goes to ack_stat (0 = ACK). On ACK, the stretch, load, release and shift sequence repeats. On NACK, SCL and SDA are both released and no stretch follows.
- R10: A Stop (SDA rising while SCL is high) or a repeated Start returns the block to idle from any state: it clears buf_full and releases both lines. A Stop also clears start_seen.
- R11: A non-matching address gets no acknowledge on the 9th pulse, no stretch and no irq. All further bytes, including one equal to own_addr, are ignored until the next Start.
- R12: With addr_hold_en=0, a matching address is acknowledged on the 9th pulse with no address stretch and no host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | DATA_W-1 | Own 7-bit target address |
| addr_hold_en | input | 1 | Host decides address ACK while SCL is held |
| start_ie | input | 1 | Raise irq on Start |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| host_wr | input | 1 | Load host_wdata into the transmit buffer |
| host_wdata | input | DATA_W | Byte to transmit |
| host_rd | input | 1 | Buffer read strobe, clears buf_full |
| host_rel | input | 1 | Set clock release |
| host_ack_data | input | 1 | Address reply: 0 ACK, 1 NACK |
| host_irq_clr | input | 1 | Clear irq |
| buf_data | output | DATA_W | Last received address byte |
| buf_full | output | 1 | Buffer holds unread or unsent data |
| clk_rel | output | 1 | Clock release bit (0 = SCL held) |
| ack_stat | output | 1 | Controller's reply to the last transmit byte |
| ack_time | output | 1 | Address acknowledge phase in progress |
| rw_flag | output | 1 | R/W bit of the last matching address |
| start_seen | output | 1 | A Start seen since the last Stop |
| irq | output | 1 | Interrupt flag |

## Verification
The bench builds the block with its defaults: an 8-bit byte, which makes a 7-bit address, and a two-stage synchronizer. The bench's bus half-bit of 20 clocks is far longer than the three-cycle edge-detection latency. Because of that, every stretch can be observed on the wired-AND bus after the controller releases SCL, and the host can act on the port while the line is held. The short synchronizer also lets a repeated Start be placed in the middle of a transmit byte, so the return to idle can be checked mid-transfer.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a Start
    ST_ADDR,   // shifting in the address byte
    ST_AHOLD,  // SCL held, host choosing the address reply
    ST_AACK,   // 9th pulse of the address byte
    ST_THOLD,  // SCL held, host loading the next byte
    ST_TBITS,  // shifting a byte out
    ST_TACK,   // 9th pulse of a transmit byte
    ST_SKIP    // not addressed, ignore until Start
  } tgt_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= '1;
    else     pipe_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe_q[s] <= '1;
      else     pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2ct_bus_ev.sv
module i2ct_bus_ev (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // SCL must be high on both samples so that a data change made together
  // with an SCL release is never taken for a bus condition.
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              addr_hold_en,
  input  logic              start_ie,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_rel,
  input  logic              host_ack_data,
  input  logic              host_irq_clr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              clk_rel,
  output logic              ack_stat,
  output logic              ack_time,
  output logic              rw_flag,
  output logic              start_seen,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, ev_start, ev_stop;

  i2ct_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  i2ct_bus_ev u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  tgt_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              acked_q;
  logic              scl_oe_q, sda_oe_q, buf_full_q, clk_rel_q;
  logic              ack_stat_q, ack_time_q, rw_q, start_q, irq_q;

  logic              addr_hit;
  logic [DATA_W-1:0] tx_next;

  assign addr_hit = (rx_sh_q[DATA_W-1:1] == own_addr);
  assign tx_next  = host_wr ? host_wdata : tx_sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rx_q       <= '0;
      acked_q    <= 1'b0;
      scl_oe_q   <= 1'b0;
      sda_oe_q   <= 1'b0;
      buf_full_q <= 1'b0;
      clk_rel_q  <= 1'b1;
      ack_stat_q <= 1'b0;
      ack_time_q <= 1'b0;
      rw_q       <= 1'b0;
      start_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (host_rd)      buf_full_q <= 1'b0;
      if (host_irq_clr) irq_q      <= 1'b0;

      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_s};
            cnt_q   <= cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == FULL_CNT) begin
            if (addr_hit) begin
              rx_q       <= rx_sh_q;
              rw_q       <= rx_sh_q[0];
              buf_full_q <= 1'b1;
              ack_time_q <= 1'b1;
              if (addr_hold_en) begin
                clk_rel_q <= 1'b0;
                scl_oe_q  <= 1'b1;
                irq_q     <= 1'b1;
                st_q      <= ST_AHOLD;
              end else begin
                sda_oe_q <= 1'b1;
                acked_q  <= 1'b1;
                st_q     <= ST_AACK;
              end
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end

        ST_AHOLD: begin
          if (host_rel) begin
            clk_rel_q <= 1'b1;
            scl_oe_q  <= 1'b0;
            sda_oe_q  <= ~host_ack_data;
            acked_q   <= ~host_ack_data;
            st_q      <= ST_AACK;
          end
        end

        ST_AACK: begin
          if (scl_fall) begin
            ack_time_q <= 1'b0;
            sda_oe_q   <= 1'b0;
            if (acked_q && rw_q) begin
              clk_rel_q <= 1'b0;
              scl_oe_q  <= 1'b1;
              irq_q     <= 1'b1;
              st_q      <= ST_THOLD;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end

        ST_THOLD: begin
          if (host_wr) begin
            tx_sh_q    <= host_wdata;
            buf_full_q <= 1'b1;
          end
          if (host_rel) begin
            tx_sh_q   <= tx_next;
            clk_rel_q <= 1'b1;
            scl_oe_q  <= 1'b0;
            sda_oe_q  <= ~tx_next[DATA_W-1];
            cnt_q     <= '0;
            st_q      <= ST_TBITS;
          end
        end

        ST_TBITS: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe_q   <= 1'b0;
              buf_full_q <= 1'b0;
              st_q       <= ST_TACK;
            end else begin
              tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
              sda_oe_q <= ~tx_sh_q[DATA_W-2];
              cnt_q    <= cnt_q + CNT_W'(1);
            end
          end
        end

        ST_TACK: begin
          if (scl_rise) begin
            ack_stat_q <= sda_s;
          end else if (scl_fall) begin
            if (!ack_stat_q) begin
              clk_rel_q <= 1'b0;
              scl_oe_q  <= 1'b1;
              irq_q     <= 1'b1;
              st_q      <= ST_THOLD;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end

        default: ;
      endcase

      // bus conditions override whatever the byte machine decided
      if (ev_start || ev_stop) begin
        cnt_q      <= '0;
        scl_oe_q   <= 1'b0;
        sda_oe_q   <= 1'b0;
        buf_full_q <= 1'b0;
        clk_rel_q  <= 1'b1;
        ack_time_q <= 1'b0;
        if (ev_start) begin
          st_q    <= ST_ADDR;
          start_q <= 1'b1;
          if (start_ie) irq_q <= 1'b1;
        end else begin
          st_q    <= ST_IDLE;
          start_q <= 1'b0;
        end
      end
    end
  end

  assign scl_oe     = scl_oe_q;
  assign sda_oe     = sda_oe_q;
  assign buf_data   = rx_q;
  assign buf_full   = buf_full_q;
  assign clk_rel    = clk_rel_q;
  assign ack_stat   = ack_stat_q;
  assign ack_time   = ack_time_q;
  assign rw_flag    = rw_q;
  assign start_seen = start_q;
  assign irq        = irq_q;
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic clk_rel,
  input logic irq,
  input logic buf_full,
  input logic ev_stop,
  input logic scl_s
);
  // R1: leaving reset, the lines are free and the flags are clear
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!scl_oe && !sda_oe && clk_rel && !irq && !buf_full));

  // R3: clock release off always means SCL is pulled low
  a_r3_hold_pulls_scl: assert property (@(posedge clk) disable iff (rst)
    !clk_rel |-> scl_oe);

  // R3: each new stretch comes with the interrupt flag
  a_r3_stretch_irq: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_rel) |-> irq);

  // R10: a Stop frees both lines and empties the buffer
  a_r10_stop_frees: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!scl_oe && !sda_oe && !buf_full && clk_rel));

  // R8: the SDA drive only moves while synchronized SCL is low
  a_r8_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));
endmodule

bind i2ct_target i2ct_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .clk_rel  (clk_rel),
  .irq      (irq),
  .buf_full (buf_full),
  .ev_stop  (ev_stop),
  .scl_s    (scl_s)
);

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 20;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_bus, sda_bus;
  logic addr_hold_en = 1'b1, start_ie = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_rel = 1'b0;
  logic host_ack_data = 1'b0, host_irq_clr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic scl_oe, sda_oe, buf_full, clk_rel, ack_stat, ack_time, rw_flag;
  logic start_seen, irq;
  logic [7:0] buf_data;

  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2ct_target u_dut (
    .clk(clk), .rst(rst), .own_addr(OWN), .addr_hold_en(addr_hold_en),
    .start_ie(start_ie), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rel(host_rel),
    .host_ack_data(host_ack_data), .host_irq_clr(host_irq_clr),
    .buf_data(buf_data), .buf_full(buf_full), .clk_rel(clk_rel),
    .ack_stat(ack_stat), .ack_time(ack_time), .rw_flag(rw_flag),
    .start_seen(start_seen), .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_high();
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic m_clock(input logic b, output logic s);
    m_sda_low = ~b;
    cyc(HB);
    m_scl_low = 1'b0;
    wait_high();
    cyc(HB);
    s = sda_bus;
    m_scl_low = 1'b1;
    cyc(5);
  endtask

  task automatic m_byte_out(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) m_clock(b[i], s);
  endtask

  task automatic m_byte_in(output logic [7:0] v);
    logic s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_clock(1'b1, s);
      v = {v[6:0], s};
    end
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    cyc(HB);
    m_scl_low = 1'b0;
    wait_high();
    cyc(HB);
    m_sda_low = 1'b1;
    cyc(HB);
    m_scl_low = 1'b1;
    cyc(HB);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    cyc(HB);
    m_scl_low = 1'b0;
    wait_high();
    cyc(HB);
    m_sda_low = 1'b0;
    cyc(HB);
  endtask

  task automatic h_rel();
    host_rel = 1'b1; cyc(1); host_rel = 1'b0; cyc(1);
  endtask

  task automatic h_rd();
    host_rd = 1'b1; cyc(1); host_rd = 1'b0; cyc(1);
  endtask

  task automatic h_irq_clr();
    host_irq_clr = 1'b1; cyc(1); host_irq_clr = 1'b0; cyc(1);
  endtask

  // driver side of the scoreboard: a loaded byte is expected on the bus
  task automatic h_load(input logic [7:0] b, input bit expect_it);
    host_wdata = b;
    host_wr = 1'b1; cyc(1); host_wr = 1'b0; cyc(1);
    if (expect_it) exp_q.push_back(b);
  endtask

  // monitor side: compare every byte the controller read
  initial begin
    forever begin
      logic [7:0] o, e;
      wait (obs_q.size() > 0);
      o = obs_q.pop_front();
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk("R8", "byte read MSB first", {24'h0, o}, {24'h0, e});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] v;
    cyc(5);
    chk("R1", "scl_oe", {31'h0, scl_oe}, 0);
    chk("R1", "sda_oe", {31'h0, sda_oe}, 0);
    chk("R1", "clk_rel", {31'h0, clk_rel}, 1);
    chk("R1", "irq/buf_full/start_seen", {29'h0, irq, buf_full, start_seen}, 0);
    @(negedge clk) rst = 1'b0;
    cyc(5);

    // R2: Start without and with the start interrupt
    m_start();
    chk("R2", "start_seen", {31'h0, start_seen}, 1);
    chk("R2", "irq with start_ie=0", {31'h0, irq}, 0);
    m_stop();
    chk("R10", "start_seen after Stop", {31'h0, start_seen}, 0);
    start_ie = 1'b1;
    m_start();
    chk("R2", "irq with start_ie=1", {31'h0, irq}, 1);
    start_ie = 1'b0;
    h_irq_clr();

    // R11: address mismatch, then own address with no new Start
    m_byte_out({7'h15, 1'b0});
    cyc(20);
    chk("R11", "no irq on mismatch", {31'h0, irq}, 0);
    chk("R11", "no stretch on mismatch", {31'h0, clk_rel}, 1);
    m_clock(1'b1, s);
    chk("R11", "9th pulse SDA on mismatch", {31'h0, s}, 1);
    m_byte_out({OWN, 1'b0});
    cyc(20);
    chk("R11", "own address ignored: irq", {31'h0, irq}, 0);
    chk("R11", "own address ignored: scl_oe", {31'h0, scl_oe}, 0);
    m_clock(1'b1, s);
    chk("R11", "own address ignored: no ack", {31'h0, s}, 1);
    m_stop();

    // R3..R5, R7: held address, host reads, rejects the write, NACKs
    m_start();
    m_byte_out({OWN, 1'b0});
    cyc(20);
    chk("R3", "clk_rel cleared", {31'h0, clk_rel}, 0);
    chk("R3", "irq raised", {31'h0, irq}, 1);
    chk("R3", "ack_time set", {31'h0, ack_time}, 1);
    chk("R3", "buf_full set", {31'h0, buf_full}, 1);
    chk("R3", "buf_data address", {24'h0, buf_data}, 32'h54);
    m_sda_low = 1'b0;
    m_scl_low = 1'b0;
    cyc(30);
    chk("R3", "SCL held on bus", {31'h0, scl_bus}, 0);
    h_rd();
    chk("R4", "buf_full after read", {31'h0, buf_full}, 0);
    h_load(8'h99, 1'b0);
    chk("R7", "early load ignored", {31'h0, buf_full}, 0);
    h_irq_clr();
    host_ack_data = 1'b1;
    h_rel();
    m_clock(1'b1, s);
    chk("R5", "host NACK on 9th pulse", {31'h0, s}, 1);
    cyc(5);
    chk("R5", "ack_time cleared", {31'h0, ack_time}, 0);
    chk("R5", "no stretch after NACK", {31'h0, scl_oe}, 0);
    m_stop();
    chk("R10", "lines free after Stop", {30'h0, scl_oe, sda_oe}, 0);

    // R5, R6, R7, R8, R9: held read with two bytes
    m_start();
    m_byte_out({OWN, 1'b1});
    cyc(20);
    h_irq_clr();
    host_ack_data = 1'b0;
    m_sda_low = 1'b0;
    m_scl_low = 1'b0;
    h_rel();
    m_clock(1'b1, s);
    chk("R5", "host ACK on 9th pulse", {31'h0, s}, 0);
    cyc(20);
    chk("R6", "clk_rel cleared for read", {31'h0, clk_rel}, 0);
    chk("R6", "irq for read", {31'h0, irq}, 1);
    chk("R6", "rw_flag", {31'h0, rw_flag}, 1);
    m_scl_low = 1'b0;
    cyc(30);
    chk("R6", "SCL held before byte", {31'h0, scl_bus}, 0);
    h_irq_clr();
    h_load(8'hA5, 1'b1);
    chk("R7", "load sets buf_full", {31'h0, buf_full}, 1);
    h_rel();
    m_byte_in(v);
    obs_q.push_back(v);
    chk("R7", "buf_full after shift", {31'h0, buf_full}, 0);
    m_clock(1'b0, s);
    cyc(20);
    chk("R9", "ack_stat after ACK", {31'h0, ack_stat}, 0);
    chk("R9", "stretch repeats", {31'h0, clk_rel}, 0);
    chk("R9", "irq repeats", {31'h0, irq}, 1);
    h_irq_clr();
    h_load(8'h3C, 1'b1);
    h_rel();
    m_byte_in(v);
    obs_q.push_back(v);
    m_clock(1'b1, s);
    cyc(20);
    chk("R9", "ack_stat after NACK", {31'h0, ack_stat}, 1);
    chk("R9", "no stretch after NACK", {31'h0, scl_oe}, 0);
    chk("R9", "SDA free after NACK", {31'h0, sda_oe}, 0);
    chk("R9", "clk_rel after NACK", {31'h0, clk_rel}, 1);
    m_stop();

    // R12, R10: automatic ACK, then a repeated Start inside a byte
    addr_hold_en = 1'b0;
    m_start();
    m_byte_out({OWN, 1'b1});
    cyc(20);
    chk("R12", "no address stretch", {31'h0, scl_oe}, 0);
    chk("R12", "clk_rel stays set", {31'h0, clk_rel}, 1);
    m_clock(1'b1, s);
    chk("R12", "automatic ACK", {31'h0, s}, 0);
    cyc(20);
    chk("R6", "stretch before byte (auto)", {31'h0, clk_rel}, 0);
    h_irq_clr();
    h_load(8'h81, 1'b1);
    h_rel();
    m_byte_in(v);
    obs_q.push_back(v);
    m_clock(1'b0, s);
    cyc(20);
    h_load(8'hFF, 1'b0);
    h_rel();
    for (int i = 0; i < 3; i++) m_clock(1'b1, s);
    chk("R10", "buf_full mid byte", {31'h0, buf_full}, 1);
    m_start();
    chk("R10", "restart clears buf_full", {31'h0, buf_full}, 0);
    chk("R10", "restart frees lines", {30'h0, scl_oe, sda_oe}, 0);
    chk("R10", "start_seen on restart", {31'h0, start_seen}, 1);
    m_stop();
    chk("R10", "start_seen after final Stop", {31'h0, start_seen}, 0);

    cyc(10);
    chk("R8", "all bytes compared", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule